// File: doc/BRIEF.md
# MSI Termination Pending Array

This block is the landing point for message-signalled interrupt writes that a PCIe host bridge forwards inward. Each inbound write carries a vector number. The block turns that number into one bit in a two-level pending structure and holds it there until software collects it.

The structure has sixteen groups. Each group has eight 32-bit pending registers and one read-only summary register, for 4096 vectors in all. The low four bits of a vector pick the group, so consecutive vectors spread evenly across the groups. The remaining bits pick the register and the bit inside it.

Each group drives one level interrupt. A handler reads the group's summary to find the non-empty pending registers. It then reads each of those registers, which hands over the set bits and clears them in the same access.

Top module: `msi_term_array`

## Requirements
- R1: After reset all pending bits are zero, every `irq` bit is low and `rd_valid` is low.
- R2: An inbound vector V below 4096 sets bit V[8:4] of pending register V[11:9] in group V[3:0]. Bits that are already set are kept.
- R3: An inbound vector of 4096 or more changes no pending bit.
- R4: Pending register `idx` of group `g` is read at address (g << 19) | (idx << 16), with address bit 23 clear.
- R5: The summary of group `g` is read at address 0x800000 | (g << 16). Its bit x is 1 exactly when pending register x of that group is non-zero, and bits 31:8 read as zero.
- R6: A pending read returns the register's value from the request cycle. The read clears exactly those bits, and only in that register.
- R7: If a read request and an inbound write hit the same register in the same cycle, the read returns the value from before the write, and the written bit is set afterwards.
- R8: A summary read changes no pending bit.
- R9: `irq[g]` equals the OR of group g's summary bits as they stood one cycle earlier.
- R10: A read of any other address returns zero and changes no pending bit.
- R11: `rd_valid` is high in the cycle after each `rd_en` and low otherwise, and `rd_data` is presented in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| msi_valid | input | 1 | Inbound interrupt write strobe |
| msi_vec | input | 16 | Inbound vector number |
| rd_en | input | 1 | Read request |
| rd_addr | input | 24 | Read byte address |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| irq | output | 16 | Per-group level interrupt |

## Verification
An inbound write and a clear-on-read of the same pending register can land on the same clock edge. The bench drives a vector and a read of its target register on the same cycle. It expects the read to return only the older bits, and a second read to return the newly written bit alone. The bench also keeps a model of every register. It compares each read result as the result leaves the design, and this catches any case where a read clears too much or a write is lost.

// File: rtl/msi_term_pkg.sv
package msi_term_pkg;
  localparam int MT_GROUPS   = 16;
  localparam int MT_REGS     = 8;
  localparam int MT_BITS     = 32;
  localparam int MT_VEC_W    = 16;
  localparam int MT_ADDR_W   = 24;
  localparam int MT_REG_SHIFT = 16;

  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_PEND = 2'd1,
    RD_SUM  = 2'd2
  } rd_kind_e;
endpackage

// File: rtl/msi_vec_decode.sv
module msi_vec_decode #(
  parameter int NG    = 16,
  parameter int NR    = 8,
  parameter int NB    = 32,
  parameter int VEC_W = 16
) (
  input  logic                      valid_i,
  input  logic [VEC_W-1:0]          vec_i,
  output logic                      hit_o,
  output logic [$clog2(NG)-1:0]     grp_o,
  output logic [$clog2(NR)-1:0]     idx_o,
  output logic [$clog2(NB)-1:0]     bit_o
);
  localparam int GW    = $clog2(NG);
  localparam int IW    = $clog2(NR);
  localparam int BW    = $clog2(NB);
  localparam int USE_W = GW + BW + IW;

  // group in the low bits, then bit within register, then register index
  always_comb begin
    hit_o = valid_i && ((vec_i >> USE_W) == '0);
    grp_o = vec_i[0 +: GW];
    bit_o = vec_i[GW +: BW];
    idx_o = vec_i[GW+BW +: IW];
  end
endmodule

// File: rtl/msi_addr_decode.sv
module msi_addr_decode
  import msi_term_pkg::*;
#(
  parameter int NG        = 16,
  parameter int NR        = 8,
  parameter int ADDR_W    = 24,
  parameter int REG_SHIFT = 16,
  parameter logic [ADDR_W-1:0] SUM_BASE = 24'h800000
) (
  input  logic [ADDR_W-1:0]      addr_i,
  output rd_kind_e               kind_o,
  output logic [$clog2(NG)-1:0]  grp_o,
  output logic [$clog2(NR)-1:0]  idx_o
);
  localparam int GW       = $clog2(NG);
  localparam int IW       = $clog2(NR);
  localparam int PEND_TOP = REG_SHIFT + IW + GW;
  localparam int SUM_TOP  = REG_SHIFT + GW;

  logic low_clear, pend_hit, sum_hit;

  always_comb begin
    low_clear = (addr_i[REG_SHIFT-1:0] == '0);
    pend_hit  = low_clear && ((addr_i >> PEND_TOP) == '0);
    sum_hit   = low_clear && ((addr_i >> SUM_TOP) == (SUM_BASE >> SUM_TOP));
    kind_o    = RD_NONE;
    grp_o     = '0;
    idx_o     = '0;
    if (pend_hit) begin
      kind_o = RD_PEND;
      grp_o  = addr_i[REG_SHIFT+IW +: GW];
      idx_o  = addr_i[REG_SHIFT +: IW];
    end else if (sum_hit) begin
      kind_o = RD_SUM;
      grp_o  = addr_i[REG_SHIFT +: GW];
    end
  end
endmodule

// File: rtl/msi_pend_group.sv
module msi_pend_group #(
  parameter int NR = 8,
  parameter int NB = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    set_en,
  input  logic [$clog2(NR)-1:0]   set_idx,
  input  logic [$clog2(NB)-1:0]   set_bit,
  input  logic                    clr_en,
  input  logic [$clog2(NR)-1:0]   clr_idx,
  output logic [NR-1:0][NB-1:0]   pend_o,
  output logic [NR-1:0]           sum_o,
  output logic                    irq_o
);
  logic [NR-1:0][NB-1:0] pend_q;

  for (genvar r = 0; r < NR; r++) begin : g_reg
    logic [NB-1:0] set_mask, keep_mask;
    always_comb begin
      set_mask  = (set_en && set_idx == r) ? (NB'(1) << set_bit) : '0;
      keep_mask = (clr_en && clr_idx == r) ? '0 : '1;
    end
    // the set mask is applied after the clear, so a write landing with a read survives
    always_ff @(posedge clk) begin
      if (rst) pend_q[r] <= '0;
      else     pend_q[r] <= (pend_q[r] & keep_mask) | set_mask;
    end
    assign sum_o[r] = |pend_q[r];

    AST_CLEAR_NEEDS_READ: assert property (@(posedge clk) disable iff (rst)
      ((|($past(pend_q[r]) & ~pend_q[r])) |-> $past(clr_en && clr_idx == r))); // R6
  end

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= |sum_o;
  end

  assign pend_o = pend_q;

  AST_SET_LANDS: assert property (@(posedge clk) disable iff (rst)
    set_en |=> pend_q[$past(set_idx)][$past(set_bit)]); // R7
  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    irq_o == $past(|pend_q)); // R9
endmodule

// File: rtl/msi_term_array.sv
module msi_term_array
  import msi_term_pkg::*;
#(
  parameter int NG        = MT_GROUPS,
  parameter int NR        = MT_REGS,
  parameter int NB        = MT_BITS,
  parameter int VEC_W     = MT_VEC_W,
  parameter int ADDR_W    = MT_ADDR_W,
  parameter int REG_SHIFT = MT_REG_SHIFT,
  parameter logic [ADDR_W-1:0] SUM_BASE = 24'h800000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              msi_valid,
  input  logic [VEC_W-1:0]  msi_vec,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_valid,
  output logic [NB-1:0]     rd_data,
  output logic [NG-1:0]     irq
);
  localparam int GW = $clog2(NG);
  localparam int IW = $clog2(NR);
  localparam int BW = $clog2(NB);

  logic          v_hit;
  logic [GW-1:0] v_grp;
  logic [IW-1:0] v_idx;
  logic [BW-1:0] v_bit;

  msi_vec_decode #(.NG(NG), .NR(NR), .NB(NB), .VEC_W(VEC_W)) u_vdec (
    .valid_i(msi_valid), .vec_i(msi_vec),
    .hit_o(v_hit), .grp_o(v_grp), .idx_o(v_idx), .bit_o(v_bit)
  );

  rd_kind_e      a_kind;
  logic [GW-1:0] a_grp;
  logic [IW-1:0] a_idx;

  msi_addr_decode #(.NG(NG), .NR(NR), .ADDR_W(ADDR_W), .REG_SHIFT(REG_SHIFT),
                    .SUM_BASE(SUM_BASE)) u_adec (
    .addr_i(rd_addr), .kind_o(a_kind), .grp_o(a_grp), .idx_o(a_idx)
  );

  logic [NR-1:0][NB-1:0] pend_w [NG];
  logic [NR-1:0]         sum_w  [NG];

  for (genvar g = 0; g < NG; g++) begin : g_grp
    logic set_g, clr_g;
    assign set_g = v_hit && (v_grp == g);
    assign clr_g = rd_en && (a_kind == RD_PEND) && (a_grp == g);
    msi_pend_group #(.NR(NR), .NB(NB)) u_grp (
      .clk(clk), .rst(rst),
      .set_en(set_g), .set_idx(v_idx), .set_bit(v_bit),
      .clr_en(clr_g), .clr_idx(a_idx),
      .pend_o(pend_w[g]), .sum_o(sum_w[g]), .irq_o(irq[g])
    );
  end

  logic [NB-1:0] rd_next;
  always_comb begin
    case (a_kind)
      RD_PEND: rd_next = pend_w[a_grp][a_idx];
      RD_SUM:  rd_next = NB'(sum_w[a_grp]);
      default: rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_next;
    end
  end

  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid); // R11
  AST_RD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_valid); // R11
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_en && a_kind == RD_NONE) |=> (rd_data == '0)); // R10
  AST_SUM_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_en && a_kind == RD_SUM) |=> (rd_data[NB-1:NR] == '0)); // R5
endmodule

// File: tb/msi_term_array_test.sv
`timescale 1ns/1ps
module msi_term_array_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        msi_valid = 1'b0;
  logic [15:0] msi_vec = '0;
  logic        rd_en = 1'b0;
  logic [23:0] rd_addr = '0;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic [15:0] irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] model [16][8];
  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #2.5 clk = ~clk;

  msi_term_array uut (
    .clk(clk), .rst(rst), .msi_valid(msi_valid), .msi_vec(msi_vec),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(rd_valid),
    .rd_data(rd_data), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] pa(input int g, input int idx);
    return 24'((g << 19) | (idx << 16));
  endfunction

  function automatic logic [23:0] sa(input int g);
    return 24'h800000 | 24'(g << 16);
  endfunction

  // Driver: applies one cycle of stimulus and updates the model
  task automatic step(input logic w, input logic [15:0] v, input logic r,
                      input logic [23:0] a, input string tag);
    logic [31:0] e;
    @(negedge clk);
    msi_valid = w; msi_vec = v; rd_en = r; rd_addr = a;
    if (r) begin
      e = '0;
      if (a[15:0] == 0 && a[23] == 1'b0) begin
        e = model[a[22:19]][a[18:16]];
        model[a[22:19]][a[18:16]] = '0;
      end else if (a[15:0] == 0 && a[23:20] == 4'h8) begin
        for (int x = 0; x < 8; x++) e[x] = |model[a[19:16]][x];
      end
      exp_q.push_back(e);
      tag_q.push_back(tag);
    end
    if (w && v < 16'd4096)
      model[v[3:0]][v[11:9]][v[8:4]] = 1'b1;
  endtask

  task automatic idle();
    step(1'b0, '0, 1'b0, '0, "");
  endtask

  // Monitor: compares read results with the scoreboard
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R11 actual=unexpected rd_valid expected=none");
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, rd_data, e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int g = 0; g < 16; g++)
      for (int i = 0; i < 8; i++) model[g][i] = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    check("R1 irq", 32'(irq), 32'h0);
    check("R1 rd_valid", 32'(rd_valid), 32'h0);
    step(1'b0, '0, 1'b1, sa(0), "R1 summary");
    step(1'b0, '0, 1'b1, pa(15, 7), "R1 pending");

    // R2 vector placement
    step(1'b1, 16'd0, 1'b0, '0, "");
    step(1'b1, 16'd31, 1'b0, '0, "");
    step(1'b1, 16'd4095, 1'b0, '0, "");
    step(1'b1, 16'd291, 1'b0, '0, "");
    // R3 out-of-range vectors
    step(1'b1, 16'd4096, 1'b0, '0, "");
    step(1'b1, 16'hFFFF, 1'b0, '0, "");
    step(1'b1, 16'd4111, 1'b0, '0, "");
    idle();
    step(1'b0, '0, 1'b1, pa(0, 0), "R2 R4 g0 idx0");
    step(1'b0, '0, 1'b1, pa(3, 0), "R2 R4 g3 idx0");
    step(1'b0, '0, 1'b1, sa(15), "R5 summary g15");
    step(1'b0, '0, 1'b1, sa(15), "R8 summary repeat");
    step(1'b0, '0, 1'b1, pa(15, 7), "R6 read g15 idx7");
    step(1'b0, '0, 1'b1, pa(15, 7), "R6 reread cleared");
    step(1'b0, '0, 1'b1, pa(15, 0), "R3 R6 g15 idx0 untouched");
    step(1'b0, '0, 1'b1, sa(15), "R5 summary after clear");
    step(1'b0, '0, 1'b1, sa(0), "R3 summary g0");

    // R9 irq timing
    idle(); idle();
    check("R9 irq idle", 32'(irq), 32'h0);
    step(1'b1, 16'd645, 1'b0, '0, "");
    idle();
    check("R9 irq one cycle later", 32'(irq[5]), 32'h0);
    idle();
    check("R9 irq raised", 32'(irq[5]), 32'h1);
    check("R9 other groups", 32'(irq & ~16'h0020), 32'h0);
    step(1'b0, '0, 1'b1, pa(5, 1), "R9 clear g5");
    idle();
    check("R11 rd_valid", 32'(rd_valid), 32'h1);
    check("R9 irq still high", 32'(irq[5]), 32'h1);
    idle();
    check("R11 rd_valid drop", 32'(rd_valid), 32'h0);
    check("R9 irq dropped", 32'(irq[5]), 32'h0);

    // R7 same-cycle write and read
    step(1'b1, 16'd307, 1'b0, '0, "");
    step(1'b1, 16'd83, 1'b1, pa(3, 0), "R7 read during write");
    step(1'b0, '0, 1'b1, pa(3, 0), "R7 written bit kept");

    // R10 unmapped reads
    step(1'b1, 16'd0, 1'b0, '0, "");
    step(1'b0, '0, 1'b1, 24'h000004, "R10 low offset");
    step(1'b0, '0, 1'b1, 24'h900000, "R10 above summary");
    step(1'b0, '0, 1'b1, 24'hC00000, "R10 high region");
    step(1'b0, '0, 1'b1, pa(0, 0), "R10 pending kept");

    // R2 fill a whole register back to back
    for (int b = 0; b < 32; b++)
      step(1'b1, 16'(2 + 16 * (4 * 32 + b)), 1'b0, '0, "");
    idle();
    step(1'b0, '0, 1'b1, sa(2), "R5 summary g2");
    step(1'b0, '0, 1'b1, pa(2, 4), "R2 full register");
    step(1'b0, '0, 1'b1, pa(2, 4), "R6 full cleared");

    idle(); idle(); idle();
    check("R11 scoreboard drained", 32'(exp_q.size()), 32'h0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule